// File: doc/BRIEF.md
# Programmable Burst Column Address Generator

This block produces the column addresses of a read or write burst inside a synchronous DRAM, one address per clock. A column command (`cmd_go` with `cmd_col`) starts a burst. The length and the ordering of the burst are taken from the mode inputs in that same cycle. Fixed bursts of 1, 2, 4 or 8 columns stay inside their aligned block. They use either sequential ordering or interleaved ordering.

A full-page burst walks the whole 256-column row in sequential order and wraps from the last column back to zero. It keeps running until a burst-stop request or a new column command ends it. A new column command is accepted in any cycle and restarts the burst from its own column with its own mode. The output `col_valid` marks the cycles that carry a burst address.

Top module: `colburst_gen`

## Requirements
- R1: After a synchronous reset, `col_valid` is 0 and `col_out` is 0. While no burst is running, `col_out` reads 0.
- R2: `mode_len` selects the burst length: code 0 gives 1 column, 1 gives 2, 2 gives 4 and 3 gives 8. Codes 4 to 7 give full page. A fixed burst presents exactly that many addresses, and `col_valid` is 0 in the cycle that follows the last one.
- R3: When `cmd_go` is high at a clock edge, `col_out` equals `cmd_col` and `col_valid` is 1 in the cycle after that edge. A new address follows on each later cycle.
- R4: With `mode_ilv`=0 and a fixed length BL, address k of the burst has the bits above the low log2(BL) bits equal to those of the start column. Its low log2(BL) bits equal (start + k) mod BL.
- R5: With `mode_ilv`=1 and a fixed length BL, address k is the start column XOR k, with k confined to the low log2(BL) bits.
- R6: A full-page burst gives address k = (start + k) mod 256, whatever the value of `mode_ilv`. It continues past 256 addresses until it is stopped or restarted.
- R7: `cmd_stop` high at an edge without `cmd_go` ends a running burst, so `col_valid` is 0 in the next cycle. While the block is idle, `cmd_stop` has no effect.
- R8: `cmd_go` during a running burst restarts it from the new column with the new mode. When `cmd_go` and `cmd_stop` are high together, `cmd_go` wins.
- R9: The block samples `mode_len` and `mode_ilv` only with `cmd_go`. Changing them during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| cmd_go | input | 1 | Column command pulse: start or restart a burst |
| cmd_col | input | COL_W | Start column of the command |
| cmd_stop | input | 1 | Burst-stop request |
| col_out | output | COL_W | Current burst column address |
| col_valid | output | 1 | Burst active, `col_out` valid |

## Verification
The bench builds the block with its default column width of 8. With that width a full-page burst is 256 columns long, so the bench can drive one past the wrap from column 255 to 0 and keep it running beyond a whole row before it stops it. The same width lets start columns near 0xFF and in the middle of the row show that fixed bursts keep their upper bits in both orders.

// File: rtl/colburst_pkg.sv
package colburst_pkg;

    localparam int LEN_CODE_W = 3;
    localparam int SPAN_LOG_W = 2;

    localparam logic [LEN_CODE_W-1:0] LEN_ONE   = 3'd0;
    localparam logic [LEN_CODE_W-1:0] LEN_TWO   = 3'd1;
    localparam logic [LEN_CODE_W-1:0] LEN_FOUR  = 3'd2;
    localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'd3;

    // Latched burst mode, held for the whole burst.
    typedef struct packed {
        logic                  full;      // run to the end of the row and wrap
        logic                  ilv;       // interleaved ordering
        logic [SPAN_LOG_W-1:0] span_log;  // log2 of the fixed length
    } burst_mode_t;

    function automatic burst_mode_t decode_mode(
        input logic [LEN_CODE_W-1:0] code,
        input logic                  ilv
    );
        burst_mode_t m;
        m.full     = (code > LEN_EIGHT);
        m.ilv      = ilv & ~m.full;
        m.span_log = m.full ? '0 : code[SPAN_LOG_W-1:0];
        return m;
    endfunction

endpackage

// File: rtl/colburst_span.sv
module colburst_span
    import colburst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  burst_mode_t      mode,
    output logic [COL_W-1:0] blk_mask
);
    // One mask bit per column bit: set when that bit moves during the burst.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign blk_mask[b] = mode.full || (b < int'(mode.span_log));
    end
endmodule

// File: rtl/colburst_seq.sv
module colburst_seq
    import colburst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LEN_CODE_W-1:0] mode_len,
    input  logic                  mode_ilv,
    input  logic                  cmd_go,
    input  logic [COL_W-1:0]      cmd_col,
    input  logic                  cmd_stop,
    input  logic [COL_W-1:0]      blk_mask,
    output logic                  active,
    output burst_mode_t           mode_q,
    output logic [COL_W-1:0]      base_q,
    output logic [COL_W-1:0]      idx_q
);
    logic last_beat;

    assign last_beat = !mode_q.full && (idx_q == blk_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            mode_q <= '0;
            base_q <= '0;
            idx_q  <= '0;
        end else if (cmd_go) begin
            active <= 1'b1;
            mode_q <= decode_mode(mode_len, mode_ilv);
            base_q <= cmd_col;
            idx_q  <= '0;
        end else if (active) begin
            if (cmd_stop || last_beat) begin
                active <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/colburst_map.sv
module colburst_map
    import colburst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             active,
    input  logic             ilv,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] blk_mask,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;

    assign sum     = base + idx;
    assign seq_col = (base & ~blk_mask) | (sum & blk_mask);
    assign ilv_col = base ^ (idx & blk_mask);

    always_comb begin
        if (!active) col = '0;
        else if (ilv) col = ilv_col;
        else          col = seq_col;
    end
endmodule

// File: rtl/colburst_gen.sv
module colburst_gen
    import colburst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LEN_CODE_W-1:0] mode_len,
    input  logic                  mode_ilv,
    input  logic                  cmd_go,
    input  logic [COL_W-1:0]      cmd_col,
    input  logic                  cmd_stop,
    output logic [COL_W-1:0]      col_out,
    output logic                  col_valid
);
    burst_mode_t      mode_q;
    logic [COL_W-1:0] blk_mask;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic             active;
    logic             cfg_full;
    logic             cfg_single;

    colburst_span #(.COL_W(COL_W)) u_span (
        .mode     (mode_q),
        .blk_mask (blk_mask)
    );

    colburst_seq #(.COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_len (mode_len),
        .mode_ilv (mode_ilv),
        .cmd_go   (cmd_go),
        .cmd_col  (cmd_col),
        .cmd_stop (cmd_stop),
        .blk_mask (blk_mask),
        .active   (active),
        .mode_q   (mode_q),
        .base_q   (base_q),
        .idx_q    (idx_q)
    );

    colburst_map #(.COL_W(COL_W)) u_map (
        .active   (active),
        .ilv      (mode_q.ilv),
        .base     (base_q),
        .idx      (idx_q),
        .blk_mask (blk_mask),
        .col      (col_out)
    );

    assign col_valid  = active;
    assign cfg_full   = mode_q.full;
    assign cfg_single = !mode_q.full && (mode_q.span_log == '0);
endmodule

// File: rtl/colburst_chk.sv
module colburst_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_go,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_stop,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             cfg_full,
    input logic             cfg_single
);
    assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !col_valid);

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !col_valid |-> col_out == '0);

    assert_single_end_R2: assert property (@(posedge clk) disable iff (rst)
        (col_valid && cfg_single && !cmd_go) |=> !col_valid);

    assert_start_load_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> (col_valid && col_out == $past(cmd_col)));

    assert_fullpage_step_R6: assert property (@(posedge clk) disable iff (rst)
        (col_valid && cfg_full && !cmd_go && !cmd_stop) |=>
        (col_valid && col_out == COL_W'($past(col_out) + 1'b1)));

    assert_stop_end_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_stop && !cmd_go) |=> !col_valid);
endmodule

bind colburst_gen colburst_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_go     (cmd_go),
    .cmd_col    (cmd_col),
    .cmd_stop   (cmd_stop),
    .col_out    (col_out),
    .col_valid  (col_valid),
    .cfg_full   (cfg_full),
    .cfg_single (cfg_single)
);

// File: tb/tb_colburst_gen.sv
module tb_colburst_gen;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       mode_len = '0;
    logic             mode_ilv = 1'b0;
    logic             cmd_go = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    colburst_gen #(.COL_W(COL_W)) dut (.*);

    // {len code, ilv, start col, beat count, last column}
    typedef struct packed {
        logic [2:0] len;
        logic       ilv;
        logic [7:0] col;
        logic [3:0] beats;
        logic [7:0] last;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 8'h35, 4'd1, 8'h35},
        '{3'd1, 1'b0, 8'h35, 4'd2, 8'h34},
        '{3'd2, 1'b0, 8'h35, 4'd4, 8'h34},
        '{3'd3, 1'b0, 8'h35, 4'd8, 8'h34},
        '{3'd3, 1'b1, 8'h35, 4'd8, 8'h32},
        '{3'd2, 1'b1, 8'hA2, 4'd4, 8'hA1},
        '{3'd1, 1'b1, 8'hFF, 4'd2, 8'hFE},
        '{3'd3, 1'b0, 8'hFE, 4'd8, 8'hFD}
    };

    function automatic logic [7:0] model(input logic [7:0] s, input int k,
                                         input logic [2:0] len, input logic ilv);
        logic [7:0] m;
        if (len > 3'd3) return 8'(int'(s) + k);
        m = 8'((1 << len) - 1);
        if (ilv) return s ^ (8'(k) & m);
        return (s & ~m) | (8'(int'(s) + k) & m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue a command; returns at the negedge where beat 0 is visible.
    task automatic issue(input logic [2:0] len, input logic ilv, input logic [7:0] col,
                         input logic stop);
        @(negedge clk);
        mode_len = len; mode_ilv = ilv; cmd_col = col; cmd_go = 1'b1; cmd_stop = stop;
        @(negedge clk);
        cmd_go = 1'b0; cmd_stop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 valid after reset", 32'(col_valid), 0);
        chk("R1 col after reset", 32'(col_out), 0);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].len, VECS[v].ilv, VECS[v].col, 1'b0);
            chk("R3 first beat", 32'(col_out), 32'(VECS[v].col));
            for (int k = 0; k < int'(VECS[v].beats); k++) begin
                chk(VECS[v].ilv ? "R5 beat" : "R4 beat", {23'd0, col_valid, col_out},
                    {23'd0, 1'b1, model(VECS[v].col, k, VECS[v].len, VECS[v].ilv)});
                if (k == int'(VECS[v].beats) - 1)
                    chk("R2 last column", 32'(col_out), 32'(VECS[v].last));
                @(negedge clk);
            end
            chk("R2 ends after last", 32'(col_valid), 0);
            chk("R1 idle col zero", 32'(col_out), 0);
        end

        // R6 full page, interleave ignored, wraps and runs past a row
        issue(3'd7, 1'b1, 8'hFC, 1'b0);
        for (int k = 0; k < 300; k++) begin
            if (k < 8 || k > 290)
                chk("R6 full page", {23'd0, col_valid, col_out},
                    {23'd0, 1'b1, 8'(8'hFC + k)});
            @(negedge clk);
        end
        // R7 stop ends full page
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk("R7 stop ends full page", 32'(col_valid), 0);

        // R2 codes 4..6 also full page
        issue(3'd5, 1'b0, 8'h10, 1'b0);
        repeat (12) @(negedge clk);
        chk("R2 code 5 is full page", {23'd0, col_valid, col_out}, {23'd0, 1'b1, 8'h1C});
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
        chk("R7 stop", 32'(col_valid), 0);

        // R7 stop when idle: no effect, then a burst runs normally
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
        chk("R7 idle stop no effect", {23'd0, col_valid, col_out}, 0);

        // R7 stop ends fixed burst early
        issue(3'd3, 1'b0, 8'h40, 1'b0);
        @(negedge clk);
        chk("R7 fixed beat1", 32'(col_out), 32'h41);
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
        chk("R7 fixed stopped", 32'(col_valid), 0);

        // R8 restart mid-burst with new mode
        issue(3'd3, 1'b0, 8'h10, 1'b0);
        @(negedge clk); @(negedge clk);
        chk("R8 before restart", 32'(col_out), 32'h12);
        issue(3'd1, 1'b0, 8'h80, 1'b0);
        chk("R8 restart beat0", {23'd0, col_valid, col_out}, {23'd0, 1'b1, 8'h80});
        @(negedge clk);
        chk("R8 restart beat1", 32'(col_out), 32'h81);
        @(negedge clk);
        chk("R8 restart ends", 32'(col_valid), 0);

        // R8 go beats stop in the same cycle
        issue(3'd1, 1'b0, 8'h22, 1'b1);
        chk("R8 go wins over stop", {23'd0, col_valid, col_out}, {23'd0, 1'b1, 8'h22});
        @(negedge clk);
        chk("R8 go wins beat1", 32'(col_out), 32'h23);
        @(negedge clk);

        // R9 mode changes during a burst are ignored
        issue(3'd2, 1'b0, 8'h41, 1'b0);
        mode_len = 3'd0; mode_ilv = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk("R9 mode held", {23'd0, col_valid, col_out},
                {23'd0, 1'b1, model(8'h41, k, 3'd2, 1'b0)});
            @(negedge clk);
        end
        chk("R9 burst length held", 32'(col_valid), 0);

        // R1 reset during a burst
        issue(3'd7, 1'b0, 8'h05, 1'b0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 reset clears burst", {23'd0, col_valid, col_out}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule